// File: doc/BRIEF.md
# Bus Cycle State Controller

This block decides, on every clock, what a 16-bit processor core does with its bus. The core shows it the current microcycle: whether the step opens a new address, whether it is a data transfer, its direction, and how long it lasts in half-cycles. The block also sees the halt, transfer-acknowledge, bus-error and interrupt inputs. From these it either lets the microcycle go ahead, moves into a wait, idle or frozen state, or starts bus-error exception processing.

One clock of the block is one decision. When the step goes ahead, `advance_o` is high. When the block spends the step on a repeated wait or idle cycle, `repeat_o` is high. The cost of each step in half-cycles is added into a phase counter that runs modulo 10. That counter drives a slow peripheral clock, which stays in the right phase through wait, stop and halt periods.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (running), `e_phase_o` is 0 and `e_clk_o` is low. State codes: 0 running, 1 waiting for acknowledge, 2 stopped, 3 halted.
- R2: In the running state, decisions are taken in this order of priority:
  - `stop_req_i` moves the block to stopped.
  - Otherwise, halt together with a new-address step moves it to halted without advancing.
  - Otherwise, halt on a step that opens no new address has no effect, and the step advances.
- R3: In the halted state, each cycle with halt asserted repeats an idle cycle. The first cycle with halt low goes back to running, with no repeat.
- R4: In the stopped state, the block goes back to running when `irq_level_i` is strictly greater than `irq_mask_i`. Otherwise it repeats an idle cycle, and this includes the case where the two are equal.
- R5: In the running state, a data-select step with acknowledge low and no bus error enters the waiting state. The block latches the step's length and its read flag at that point. While waiting without acknowledge or bus error, it repeats a wait cycle and shows the latched read flag on `rep_read_o`. Acknowledge returns it to running. `rep_read_o` is 0 in every other state.
- R6: With `DTACK_IMPLICIT` set, the block never enters the waiting state, and a data-select step advances whatever the acknowledge input is.
- R7: A bus error on a data-select step while running, or any bus error while waiting, raises `exc_start_o` for that cycle. The block is running on the next cycle, and the step does not advance. A bus error beats an acknowledge that arrives in the same cycle.
- R8: On each edge, `e_phase_o` becomes (phase + cost) mod 10. The cost depends on the step:
  - An advancing step costs its length plus `extra_wait_i`.
  - A wait repeat costs the latched length plus `extra_wait_i`.
  - An idle repeat costs `IDLE_LEN` plus `extra_wait_i`.
  - Any other decision costs 0.
- R9: `e_clk_o` is high exactly when `e_phase_o` is 6, 7, 8 or 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Halt request |
| dtack_i | input | 1 | Transfer acknowledge |
| berr_i | input | 1 | Bus error |
| stop_req_i | input | 1 | Core has executed a stop; idle until interrupt |
| irq_level_i | input | IRQ_W | External interrupt level |
| irq_mask_i | input | IRQ_W | Current interrupt mask |
| mc_new_addr_i | input | 1 | Current step opens a new address |
| mc_data_sel_i | input | 1 | Current step transfers data |
| mc_read_i | input | 1 | Current step is a read |
| mc_len_i | input | LEN_W | Current step length in half-cycles |
| extra_wait_i | input | XW_W | Extra half-cycles reported by the bus handler |
| state_o | output | 2 | Registered state code |
| repeat_o | output | 1 | This cycle is a repeated wait or idle cycle |
| rep_read_o | output | 1 | Read flag of the held step while waiting |
| advance_o | output | 1 | Current step is performed |
| exc_start_o | output | 1 | Start bus-error exception |
| e_phase_o | output | 4 | Phase of the slow clock, 0 to 9 |
| e_clk_o | output | 1 | Slow peripheral clock |

## Verification
`repeat_o`, `advance_o`, `exc_start_o` and `rep_read_o` are combinational in the registered state and the present inputs. They are due in the same cycle as the stimulus, so the bench drives inputs on the falling edge and samples these outputs 1 time unit later. `state_o`, `e_phase_o` and `e_clk_o` take their new value one rising edge after the decision. The bench compares them at the following falling edge, just before it drives new inputs, against a reference state and phase that it has advanced from the requirements. Two instances run the same stimulus, one with implicit acknowledge and one without, during directed corner cases and a long pseudo-random sweep.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_STOP = 2'd2,
        ST_HALT = 2'd3
    } bsc_state_e;

    typedef enum logic [1:0] {
        COST_NONE = 2'd0,
        COST_LIVE = 2'd1,
        COST_HELD = 2'd2,
        COST_IDLE = 2'd3
    } bsc_cost_e;

endpackage

// File: rtl/bsc_sequencer.sv
module bsc_sequencer
    import bsc_pkg::*;
#(
    parameter int  LEN_W          = 4,
    parameter int  IRQ_W          = 3,
    parameter bit  DTACK_IMPLICIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             dtack_i,
    input  logic             berr_i,
    input  logic             stop_req_i,
    input  logic [IRQ_W-1:0] irq_level_i,
    input  logic [IRQ_W-1:0] irq_mask_i,
    input  logic             mc_new_addr_i,
    input  logic             mc_data_sel_i,
    input  logic             mc_read_i,
    input  logic [LEN_W-1:0] mc_len_i,
    output bsc_state_e       state_o,
    output logic [LEN_W-1:0] held_len_o,
    output bsc_cost_e        cost_sel_o,
    output logic             repeat_o,
    output logic             rep_read_o,
    output logic             advance_o,
    output logic             exc_start_o
);

    typedef struct packed {
        bsc_state_e       state;
        logic [LEN_W-1:0] held_len;
        logic             held_read;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        cost_sel_o  = COST_NONE;
        repeat_o    = 1'b0;
        advance_o   = 1'b0;
        exc_start_o = 1'b0;
        unique case (seq_q.state)
            ST_RUN: begin
                if (stop_req_i) begin
                    seq_d.state = ST_STOP;
                end else if (halt_i && mc_new_addr_i) begin
                    seq_d.state = ST_HALT;
                end else if (mc_data_sel_i && berr_i) begin
                    exc_start_o = 1'b1;
                end else if (mc_data_sel_i && !dtack_i && !DTACK_IMPLICIT) begin
                    seq_d.state     = ST_WAIT;
                    seq_d.held_len  = mc_len_i;
                    seq_d.held_read = mc_read_i;
                end else begin
                    advance_o  = 1'b1;
                    cost_sel_o = COST_LIVE;
                end
            end
            ST_WAIT: begin
                if (berr_i) begin
                    exc_start_o = 1'b1;
                    seq_d.state = ST_RUN;
                end else if (dtack_i) begin
                    seq_d.state = ST_RUN;
                end else begin
                    repeat_o   = 1'b1;
                    cost_sel_o = COST_HELD;
                end
            end
            ST_STOP: begin
                if (irq_level_i > irq_mask_i) begin
                    seq_d.state = ST_RUN;
                end else begin
                    repeat_o   = 1'b1;
                    cost_sel_o = COST_IDLE;
                end
            end
            ST_HALT: begin
                if (!halt_i) begin
                    seq_d.state = ST_RUN;
                end else begin
                    repeat_o   = 1'b1;
                    cost_sel_o = COST_IDLE;
                end
            end
            default: seq_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_RUN, held_len: '0, held_read: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o    = seq_q.state;
    assign held_len_o = seq_q.held_len;
    assign rep_read_o = (seq_q.state == ST_WAIT) && seq_q.held_read;

    AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && !stop_req_i && halt_i && mc_new_addr_i)
            |=> (seq_q.state == ST_HALT)); // R2

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_HALT && halt_i) |=> (seq_q.state == ST_HALT)); // R3

    AST_STOP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_STOP && irq_level_i > irq_mask_i) |=> (seq_q.state == ST_RUN)); // R4

    AST_EXC_ENDS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start_o |=> (seq_q.state == ST_RUN)); // R7

    AST_EXC_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start_o |-> !(advance_o || repeat_o)); // R7

    generate
        if (DTACK_IMPLICIT) begin : g_implicit_chk
            AST_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
                seq_q.state != ST_WAIT); // R6
        end
    endgenerate

endmodule

// File: rtl/bsc_cost.sv
module bsc_cost
    import bsc_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int XW_W     = 3,
    parameter int IDLE_LEN = 4,
    parameter int EL_W     = LEN_W + 2
) (
    input  bsc_cost_e        cost_sel_i,
    input  logic [LEN_W-1:0] mc_len_i,
    input  logic [LEN_W-1:0] held_len_i,
    input  logic [XW_W-1:0]  extra_wait_i,
    output logic [EL_W-1:0]  elapsed_o
);

    localparam logic [EL_W-1:0] IDLE_COST = EL_W'(IDLE_LEN);

    logic [EL_W-1:0] base;

    always_comb begin
        unique case (cost_sel_i)
            COST_LIVE: base = EL_W'(mc_len_i);
            COST_HELD: base = EL_W'(held_len_i);
            COST_IDLE: base = IDLE_COST;
            default:   base = '0;
        endcase
        if (cost_sel_i == COST_NONE) begin
            elapsed_o = '0;
        end else begin
            elapsed_o = base + EL_W'(extra_wait_i);
        end
    end

endmodule

// File: rtl/bsc_eclock.sv
module bsc_eclock #(
    parameter int EL_W        = 6,
    parameter int E_PERIOD    = 10,
    parameter int E_HIGH_FROM = 6,
    parameter int PH_W        = $clog2(E_PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EL_W-1:0] elapsed_i,
    output logic [PH_W-1:0] phase_o,
    output logic            e_o
);

    localparam int SUM_W = ((EL_W > PH_W) ? EL_W : PH_W) + 1;
    localparam logic [SUM_W-1:0] PERIOD_S = SUM_W'(E_PERIOD);
    localparam logic [PH_W-1:0]  HIGH_P   = PH_W'(E_HIGH_FROM);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            e;
    } ec_regs_t;

    ec_regs_t ec_d, ec_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
        sum        = SUM_W'(ec_q.phase) + SUM_W'(elapsed_i);
        wrapped    = sum % PERIOD_S;
        ec_d.phase = PH_W'(wrapped);
        ec_d.e     = (ec_d.phase >= HIGH_P);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ec_q <= '0;
        end else begin
            ec_q <= ec_d;
        end
    end

    assign phase_o = ec_q.phase;
    assign e_o     = ec_q.e;

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o < PH_W'(E_PERIOD)); // R8

    AST_PHASE_FROZEN_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed_i == '0) |=> $stable(phase_o)); // R8

    AST_E_LOW_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o < HIGH_P) |-> !e_o); // R9

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bsc_pkg::*;
#(
    parameter int LEN_W          = 4,
    parameter int XW_W           = 3,
    parameter int IRQ_W          = 3,
    parameter int IDLE_LEN       = 4,
    parameter bit DTACK_IMPLICIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             dtack_i,
    input  logic             berr_i,
    input  logic             stop_req_i,
    input  logic [IRQ_W-1:0] irq_level_i,
    input  logic [IRQ_W-1:0] irq_mask_i,
    input  logic             mc_new_addr_i,
    input  logic             mc_data_sel_i,
    input  logic             mc_read_i,
    input  logic [LEN_W-1:0] mc_len_i,
    input  logic [XW_W-1:0]  extra_wait_i,
    output logic [1:0]       state_o,
    output logic             repeat_o,
    output logic             rep_read_o,
    output logic             advance_o,
    output logic             exc_start_o,
    output logic [3:0]       e_phase_o,
    output logic             e_clk_o
);

    localparam int EL_W = LEN_W + 2;

    bsc_state_e       state;
    bsc_cost_e        cost_sel;
    logic [LEN_W-1:0] held_len;
    logic [EL_W-1:0]  elapsed;

    bsc_sequencer #(
        .LEN_W         (LEN_W),
        .IRQ_W         (IRQ_W),
        .DTACK_IMPLICIT(DTACK_IMPLICIT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_i       (halt_i),
        .dtack_i      (dtack_i),
        .berr_i       (berr_i),
        .stop_req_i   (stop_req_i),
        .irq_level_i  (irq_level_i),
        .irq_mask_i   (irq_mask_i),
        .mc_new_addr_i(mc_new_addr_i),
        .mc_data_sel_i(mc_data_sel_i),
        .mc_read_i    (mc_read_i),
        .mc_len_i     (mc_len_i),
        .state_o      (state),
        .held_len_o   (held_len),
        .cost_sel_o   (cost_sel),
        .repeat_o     (repeat_o),
        .rep_read_o   (rep_read_o),
        .advance_o    (advance_o),
        .exc_start_o  (exc_start_o)
    );

    bsc_cost #(
        .LEN_W   (LEN_W),
        .XW_W    (XW_W),
        .IDLE_LEN(IDLE_LEN),
        .EL_W    (EL_W)
    ) u_cost (
        .cost_sel_i  (cost_sel),
        .mc_len_i    (mc_len_i),
        .held_len_i  (held_len),
        .extra_wait_i(extra_wait_i),
        .elapsed_o   (elapsed)
    );

    bsc_eclock #(
        .EL_W       (EL_W),
        .E_PERIOD   (10),
        .E_HIGH_FROM(6),
        .PH_W       (4)
    ) u_eclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .elapsed_i(elapsed),
        .phase_o  (e_phase_o),
        .e_o      (e_clk_o)
    );

    assign state_o = state;

    AST_STATE_LEGAL_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !berr_i && !dtack_i) |=> (state == ST_WAIT)); // R5

endmodule

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IDLE_LEN   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt, dtack, berr, stop_req, new_addr, data_sel, rd;
    logic [2:0] irq_level, irq_mask, xw;
    logic [3:0] len;

    logic [1:0] st   [2];
    logic       rep  [2];
    logic       rrd  [2];
    logic       adv  [2];
    logic       exc  [2];
    logic [3:0] ph   [2];
    logic       ec   [2];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_st [2];
    int m_hl [2];
    int m_hr [2];
    int m_ph [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_ctrl #(.IDLE_LEN(IDLE_LEN), .DTACK_IMPLICIT(1'b0)) u_bus_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .dtack_i(dtack), .berr_i(berr),
        .stop_req_i(stop_req), .irq_level_i(irq_level), .irq_mask_i(irq_mask),
        .mc_new_addr_i(new_addr), .mc_data_sel_i(data_sel), .mc_read_i(rd),
        .mc_len_i(len), .extra_wait_i(xw), .state_o(st[0]), .repeat_o(rep[0]),
        .rep_read_o(rrd[0]), .advance_o(adv[0]), .exc_start_o(exc[0]),
        .e_phase_o(ph[0]), .e_clk_o(ec[0]));

    bus_cycle_ctrl #(.IDLE_LEN(IDLE_LEN), .DTACK_IMPLICIT(1'b1)) u_imp (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .dtack_i(dtack), .berr_i(berr),
        .stop_req_i(stop_req), .irq_level_i(irq_level), .irq_mask_i(irq_mask),
        .mc_new_addr_i(new_addr), .mc_data_sel_i(data_sel), .mc_read_i(rd),
        .mc_len_i(len), .extra_wait_i(xw), .state_o(st[1]), .repeat_o(rep[1]),
        .rep_read_o(rrd[1]), .advance_o(adv[1]), .exc_start_o(exc[1]),
        .e_phase_o(ph[1]), .e_clk_o(ec[1]));

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic string state_tag(input int k, input int s);
        if (k == 1) return "R6";
        case (s)
            1: return "R5";
            2: return "R4";
            3: return "R3";
            default: return "R2";
        endcase
    endfunction

    // Registered outputs against the reference state, before new inputs.
    task automatic check_regs();
        for (int k = 0; k < 2; k++) begin
            chk(int'(st[k]), m_st[k], state_tag(k, m_st[k]));
            chk(int'(ph[k]), m_ph[k], "R8");
            chk(int'(ec[k]), (m_ph[k] >= 6) ? 1 : 0, "R9");
        end
    endtask

    // Reference decision from the requirements; checks the same-cycle outputs
    // and advances the reference state.
    task automatic decide_and_check();
        for (int k = 0; k < 2; k++) begin
            int ns = m_st[k];
            int e_rep = 0, e_adv = 0, e_exc = 0, cost = 0;
            int e_rrd = (m_st[k] == 1) ? m_hr[k] : 0;
            string t = state_tag(k, m_st[k]);
            case (m_st[k])
                0: begin
                    if (stop_req) ns = 2;
                    else if (halt && new_addr) ns = 3;
                    else if (data_sel && berr) e_exc = 1;
                    else if (data_sel && !dtack && k == 0) begin
                        ns = 1; m_hl[k] = int'(len); m_hr[k] = int'(rd);
                    end else begin
                        e_adv = 1; cost = int'(len) + int'(xw);
                    end
                end
                1: begin
                    if (berr) begin e_exc = 1; ns = 0; end
                    else if (dtack) ns = 0;
                    else begin e_rep = 1; cost = m_hl[k] + int'(xw); end
                end
                2: begin
                    if (irq_level > irq_mask) ns = 0;
                    else begin e_rep = 1; cost = IDLE_LEN + int'(xw); end
                end
                default: begin
                    if (!halt) ns = 0;
                    else begin e_rep = 1; cost = IDLE_LEN + int'(xw); end
                end
            endcase
            chk(int'(adv[k]), e_adv, t);
            chk(int'(rep[k]), e_rep, t);
            chk(int'(exc[k]), e_exc, "R7");
            chk(int'(rrd[k]), e_rrd, "R5");
            m_st[k] = ns;
            m_ph[k] = (m_ph[k] + cost) % 10;
        end
    endtask

    task automatic step(input logic h, input logic dt, input logic be, input logic sr,
                        input logic [2:0] il, input logic [2:0] im, input logic na,
                        input logic ds, input logic r, input logic [3:0] l, input logic [2:0] x);
        @(negedge clk);
        check_regs();
        halt = h; dtack = dt; berr = be; stop_req = sr; irq_level = il; irq_mask = im;
        new_addr = na; data_sel = ds; rd = r; len = l; xw = x;
        #1;
        decide_and_check();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        logic [15:0] lf;
        halt = 0; dtack = 0; berr = 0; stop_req = 0; irq_level = 0; irq_mask = 0;
        new_addr = 0; data_sel = 0; rd = 0; len = 0; xw = 0;
        for (int k = 0; k < 2; k++) begin
            m_st[k] = 0; m_hl[k] = 0; m_hr[k] = 0; m_ph[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        for (int k = 0; k < 2; k++) begin
            chk(int'(st[k]), 0, "R1");
            chk(int'(ph[k]), 0, "R1");
            chk(int'(ec[k]), 0, "R1");
        end
        rst_n = 1'b1;

        // R8: plain advancing steps, phase wraps through 10
        step(0,1,0,0, 3'd0,3'd0, 1,0,1, 4'd4, 3'd0);
        step(0,1,0,0, 3'd0,3'd0, 0,0,1, 4'd7, 3'd2);
        // R2: halt without new address is ignored
        step(1,1,0,0, 3'd0,3'd0, 0,0,1, 4'd2, 3'd0);
        // R2/R3: halt at boundary, hold, release
        step(1,1,0,0, 3'd0,3'd0, 1,0,1, 4'd4, 3'd0);
        step(1,0,0,0, 3'd0,3'd0, 0,0,0, 4'd4, 3'd3);
        step(1,0,0,0, 3'd0,3'd0, 0,0,0, 4'd4, 3'd1);
        step(0,0,0,0, 3'd0,3'd0, 0,0,0, 4'd4, 3'd0);
        // R4: stop, equal level stays, greater wakes
        step(0,0,0,1, 3'd0,3'd3, 0,0,0, 4'd4, 3'd0);
        step(0,0,0,0, 3'd3,3'd3, 0,0,0, 4'd4, 3'd1);
        step(0,0,0,0, 3'd2,3'd3, 0,0,0, 4'd4, 3'd0);
        step(0,0,0,0, 3'd4,3'd3, 0,0,0, 4'd4, 3'd0);
        // R5/R6: data select without acknowledge, held length used
        step(0,0,0,0, 3'd0,3'd0, 1,1,1, 4'd6, 3'd0);
        step(0,0,0,0, 3'd0,3'd0, 0,1,0, 4'd15, 3'd1);
        step(0,0,0,0, 3'd0,3'd0, 0,1,0, 4'd1, 3'd0);
        step(0,1,0,0, 3'd0,3'd0, 0,1,1, 4'd6, 3'd0);
        // R7: bus error and acknowledge together while waiting
        step(0,0,0,0, 3'd0,3'd0, 1,1,0, 4'd4, 3'd0);
        step(0,1,1,0, 3'd0,3'd0, 1,1,0, 4'd4, 3'd0);
        // R7: bus error on data select while running
        step(0,1,1,0, 3'd0,3'd0, 1,1,1, 4'd4, 3'd2);
        // R7: bus error without data select has no effect
        step(0,1,1,0, 3'd0,3'd0, 1,0,1, 4'd5, 3'd0);

        // Pseudo-random sweep over all states and input mixes
        lf = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[1:0] != 2'd0 && lf[9], lf[14] | lf[0], lf[15:13] == 3'b111,
                 lf[5:2] == 4'd0, lf[8:6], lf[11:9], lf[12], lf[13], lf[7],
                 lf[3:0], lf[10:8]);
        end
        @(negedge clk);
        check_regs();
        finish_run();
    end

endmodule